// File: doc/BRIEF.md
# Serial Receiver with Per-Entry Error Queue

This block turns an asynchronous serial line into a stream of characters for a host. A strobe that pulses sixteen times per bit period paces all timing. The receiver finds the start of each character, samples the data bits near the middle of each bit cell, and optionally checks a parity bit. It then checks one or two stop bits and writes the character into a sixteen-entry queue.

Every queue entry carries the character together with four error flags: break, overrun, parity and framing. Because each flag travels with the character it concerns, the host always knows which character was damaged. The host reads the oldest entry directly from the read port and removes it with a one-cycle pop request. The empty and full outputs describe how many entries the queue holds. Static configuration inputs select the character length, the number of stop bits, whether parity is used, and whether parity is odd or even.

Top module: `uart_rx_errfifo`

## Requirements
- R1: After reset `empty` is 1 and `full` is 0.
- R2: A character framed as a low start bit, data bits sent least significant bit first, and a high stop bit is delivered on `rd_data` with all four error flags 0.
- R3: `cfg_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `rd_data` read 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. `cfg_par_odd`=1 requires an odd number of ones across the data and parity bits, and 0 requires an even number. A mismatch sets `rd_par`; a match leaves it 0.
- R5: When `cfg_two_stop` is 1, both stop bits are sampled. If either stop bit is low, `rd_frm` is set and the data is still delivered.
- R6: A stop bit sampled low sets `rd_frm`. The received data bits are kept in the entry.
- R7: If the line stays low for more than a whole character time, exactly one entry is written with `rd_brk`=1, `rd_frm`=1, `rd_par`=0 and data 0. No further character is accepted until the line has returned high.
- R8: A low pulse that has ended by the 8th strobe after the falling edge is discarded, and nothing is written.
- R9: Entries are read in arrival order. `empty` is 0 whenever at least one entry is held. `full` is 1 exactly when 16 entries are held.
- R10: A character that completes while the queue is full is dropped. The next entry written afterwards has `rd_ovr`=1, and later entries have `rd_ovr`=0.
- R11: A pop request while `empty` is 1 has no effect. The queue stays empty, and the next character is read as the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | 1 enables the parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| pop | input | 1 | Removes the oldest entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| rd_ovr | output | 1 | Overrun flag of the oldest entry |
| rd_par | output | 1 | Parity error flag of the oldest entry |
| rd_frm | output | 1 | Framing error flag of the oldest entry |
| empty | output | 1 | 1 when no entry is held |
| full | output | 1 | 1 when all 16 entries are held |

## Verification
A wrong sample phase or bit counter shows at the read port as a shifted or truncated character, or as a false framing flag. It appears on the very first character received after the fault. Wrong queue pointers or a wrong occupancy count show up as `empty` or `full` at the wrong time, or as entries read out of order. The overrun test makes this visible within one full queue of characters. A lost or misplaced pending-overrun flag shows as `rd_ovr` on the wrong entry, and it is caught when the queue is drained after an overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ovr;
    logic              par;
    logic              frm;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD,
    ST_WAITHI
  } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b1;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_two_stop,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       push_o,
  output rx_entry_t  ent_o
);
  localparam logic [3:0] MID_START = 4'd7;
  localparam logic [3:0] MID_BIT   = 4'd15;

  rx_state_t   state_q, state_d;
  logic [3:0]  tcnt_q, tcnt_d;
  logic [2:0]  bcnt_q, bcnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic        pacc_q, pacc_d;
  logic        hi_q, hi_d;
  logic        frm_q, frm_d;
  logic        sidx_q, sidx_d;
  logic [1:0]  len_q, len_d;
  logic        two_q, two_d;
  logic        pen_q, pen_d;
  logic        podd_q, podd_d;
  logic        push_d;
  rx_entry_t   ent_d;
  logic [DATA_W-1:0] aligned;
  logic        par_err;
  logic        last_bit;

  assign aligned  = sh_q >> (2'd3 - len_q);
  assign par_err  = pen_q & (pacc_q ^ podd_q);
  assign last_bit = (bcnt_q == ({1'b0, len_q} + 3'd4));

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    pacc_d  = pacc_q;
    hi_d    = hi_q;
    frm_d   = frm_q;
    sidx_d  = sidx_q;
    len_d   = len_q;
    two_d   = two_q;
    pen_d   = pen_q;
    podd_d  = podd_q;
    push_d  = 1'b0;
    ent_d   = '0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!line) begin
            state_d = ST_START;
            tcnt_d  = '0;
          end
        end
        ST_START: begin
          if (tcnt_q == MID_START) begin
            if (line) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_DATA;
              tcnt_d  = '0;
              bcnt_d  = '0;
              sh_d    = '0;
              pacc_d  = 1'b0;
              hi_d    = 1'b0;
              frm_d   = 1'b0;
              sidx_d  = 1'b0;
              len_d   = cfg_len;
              two_d   = cfg_two_stop;
              pen_d   = cfg_par_en;
              podd_d  = cfg_par_odd;
            end
          end else begin
            tcnt_d = tcnt_q + 4'd1;
          end
        end
        ST_DATA: begin
          if (tcnt_q == MID_BIT) begin
            tcnt_d = '0;
            sh_d   = {line, sh_q[DATA_W-1:1]};
            pacc_d = pacc_q ^ line;
            hi_d   = hi_q | line;
            if (last_bit) state_d = pen_q ? ST_PAR : ST_STOP;
            else          bcnt_d  = bcnt_q + 3'd1;
          end else begin
            tcnt_d = tcnt_q + 4'd1;
          end
        end
        ST_PAR: begin
          if (tcnt_q == MID_BIT) begin
            tcnt_d  = '0;
            pacc_d  = pacc_q ^ line;
            hi_d    = hi_q | line;
            state_d = ST_STOP;
          end else begin
            tcnt_d = tcnt_q + 4'd1;
          end
        end
        ST_STOP: begin
          if (tcnt_q == MID_BIT) begin
            tcnt_d = '0;
            hi_d   = hi_q | line;
            frm_d  = frm_q | !line;
            if (two_q && !sidx_q) begin
              sidx_d = 1'b1;
            end else if (!(hi_q | line)) begin
              state_d = ST_HOLD;
            end else begin
              push_d      = 1'b1;
              ent_d.data  = aligned;
              ent_d.par   = par_err;
              ent_d.frm   = frm_q | !line;
              state_d     = line ? ST_IDLE : ST_WAITHI;
            end
          end else begin
            tcnt_d = tcnt_q + 4'd1;
          end
        end
        ST_HOLD: begin
          if (line) begin
            push_d     = 1'b1;
            ent_d.data = aligned;
            ent_d.par  = par_err;
            ent_d.frm  = 1'b1;
            state_d    = ST_IDLE;
          end else if (tcnt_q == MID_BIT) begin
            push_d    = 1'b1;
            ent_d.brk = 1'b1;
            ent_d.frm = 1'b1;
            state_d   = ST_WAITHI;
          end else begin
            tcnt_d = tcnt_q + 4'd1;
          end
        end
        ST_WAITHI: begin
          if (line) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      pacc_q  <= 1'b0;
      hi_q    <= 1'b0;
      frm_q   <= 1'b0;
      sidx_q  <= 1'b0;
      len_q   <= 2'd3;
      two_q   <= 1'b0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      push_o  <= 1'b0;
      ent_o   <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      pacc_q  <= pacc_d;
      hi_q    <= hi_d;
      frm_q   <= frm_d;
      sidx_q  <= sidx_d;
      len_q   <= len_d;
      two_q   <= two_d;
      pen_q   <= pen_d;
      podd_q  <= podd_d;
      push_o  <= push_d;
      ent_o   <= ent_d;
    end
  end

  // R8
  glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && tcnt_q == MID_START && line) |=> (state_q == ST_IDLE && !push_o));

  // R7
  brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && ent_o.brk) |-> (ent_o.frm && !ent_o.par && ent_o.data == '0));

  // R3
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (bcnt_q <= ({1'b0, len_q} + 3'd4)));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t wr_ent,
  input  logic      pop,
  output rx_entry_t rd_ent,
  output logic      empty,
  output logic      full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  rx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            pend_q, pend_d;
  logic            do_wr, do_rd;
  rx_entry_t       wr_word;

  assign full  = (cnt_q == CNT_FULL);
  assign empty = (cnt_q == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_comb begin
    wr_word     = wr_ent;
    wr_word.ovr = pend_q;
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (do_wr) begin
      wr_d   = (wr_q == LAST) ? '0 : wr_q + AW'(1);
      pend_d = 1'b0;
    end else if (push) begin
      pend_d = 1'b1;
    end
    if (do_rd) rd_d = (rd_q == LAST) ? '0 : rd_q + AW'(1);
    if (do_wr && !do_rd) cnt_d = cnt_q + CW'(1);
    else if (do_rd && !do_wr) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_q] <= wr_word;
  end

  assign rd_ent = mem_q[rd_q];

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(wr_q) && full));

  // R10
  ovr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> pend_q);

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && $stable(rd_q)));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_two_stop,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic       rd_brk,
  output logic       rd_ovr,
  output logic       rd_par,
  output logic       rd_frm,
  output logic       empty,
  output logic       full
);
  logic      line;
  logic      push;
  rx_entry_t push_ent;
  rx_entry_t head;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rxd),
    .q_o   (line)
  );

  uart_rx_deser u_deser (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_16x),
    .line         (line),
    .cfg_len      (cfg_len),
    .cfg_two_stop (cfg_two_stop),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .push_o       (push),
    .ent_o        (push_ent)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .wr_ent (push_ent),
    .pop    (pop),
    .rd_ent (head),
    .empty  (empty),
    .full   (full)
  );

  assign rd_data = head.data;
  assign rd_brk  = head.brk;
  assign rd_ovr  = head.ovr;
  assign rd_par  = head.par;
  assign rd_frm  = head.frm;
endmodule

// File: tb/tb_uart_rx_errfifo.sv
module tb_uart_rx_errfifo;
  logic       clk;
  logic       rst_n;
  logic       tick_16x;
  logic       rxd;
  logic [1:0] cfg_len;
  logic       cfg_two_stop, cfg_par_en, cfg_par_odd;
  logic       pop;
  logic [7:0] rd_data;
  logic       rd_brk, rd_ovr, rd_par, rd_frm, empty, full;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [1:0] tdiv;

  uart_rx_errfifo dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .pop(pop), .rd_data(rd_data), .rd_brk(rd_brk),
    .rd_ovr(rd_ovr), .rd_par(rd_par), .rd_frm(rd_frm), .empty(empty), .full(full)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv     <= 2'd0;
      tick_16x <= 1'b0;
    end else begin
      tdiv     <= tdiv + 2'd1;
      tick_16x <= (tdiv == 2'd3);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff tick_16x);
  endtask

  task automatic drive(input logic v, input int nticks);
    @(negedge clk);
    rxd = v;
    wait_ticks(nticks);
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic send(input logic [7:0] d, input int nbits, input bit par_flip, input int bad_stop);
    logic p;
    p = cfg_par_odd;
    drive(1'b0, 16);
    for (int i = 0; i < nbits; i++) begin
      drive(d[i], 16);
      p = p ^ d[i];
    end
    if (cfg_par_en) drive(p ^ par_flip, 16);
    drive(bad_stop == 1 ? 1'b0 : 1'b1, 16);
    if (cfg_two_stop) drive(bad_stop == 2 ? 1'b0 : 1'b1, 16);
    drive(1'b1, 32);
  endtask

  task automatic expect_pop(input logic [7:0] d, input logic b, input logic o,
                            input logic p, input logic f, input string req);
    @(negedge clk);
    check(!empty, req, empty, 0);
    check(rd_data == d, req, rd_data, d);
    check({rd_brk, rd_ovr, rd_par, rd_frm} == {b, o, p, f}, req,
          {rd_brk, rd_ovr, rd_par, rd_frm}, {b, o, p, f});
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic two, input logic pe, input logic po);
    cfg_len = l; cfg_two_stop = two; cfg_par_en = pe; cfg_par_odd = po;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(empty == 1'b1, "R1 empty", empty, 1);
    check(full == 1'b0, "R1 full", full, 0);
  endtask

  task automatic t_basic;
    set_cfg(2'd3, 0, 0, 0);
    send(8'hA5, 8, 0, 0);
    expect_pop(8'hA5, 0, 0, 0, 0, "R2 A5");
    send(8'h3C, 8, 0, 0);
    expect_pop(8'h3C, 0, 0, 0, 0, "R2 3C");
    @(negedge clk);
    check(empty == 1'b1, "R9 empty after drain", empty, 1);
  endtask

  task automatic t_length;
    set_cfg(2'd0, 0, 0, 0);
    send(8'hF5, 5, 0, 0);
    expect_pop(8'h15, 0, 0, 0, 0, "R3 5-bit");
    set_cfg(2'd2, 0, 0, 0);
    send(8'h5A, 7, 0, 0);
    expect_pop(8'h5A, 0, 0, 0, 0, "R3 7-bit");
  endtask

  task automatic t_parity;
    set_cfg(2'd3, 0, 1, 0);
    send(8'h07, 8, 0, 0);
    expect_pop(8'h07, 0, 0, 0, 0, "R4 even ok");
    send(8'h07, 8, 1, 0);
    expect_pop(8'h07, 0, 0, 1, 0, "R4 even bad");
    set_cfg(2'd3, 0, 1, 1);
    send(8'hC3, 8, 0, 0);
    expect_pop(8'hC3, 0, 0, 0, 0, "R4 odd ok");
    send(8'hC3, 8, 1, 0);
    expect_pop(8'hC3, 0, 0, 1, 0, "R4 odd bad");
  endtask

  task automatic t_two_stop;
    set_cfg(2'd3, 1, 0, 0);
    send(8'h96, 8, 0, 0);
    expect_pop(8'h96, 0, 0, 0, 0, "R5 two stop ok");
    send(8'h96, 8, 0, 2);
    expect_pop(8'h96, 0, 0, 0, 1, "R5 second stop low");
  endtask

  task automatic t_framing;
    set_cfg(2'd3, 0, 0, 0);
    send(8'h55, 8, 0, 1);
    expect_pop(8'h55, 0, 0, 0, 1, "R6 stop low");
  endtask

  task automatic t_break;
    set_cfg(2'd3, 0, 0, 0);
    drive(1'b0, 16 * 25);
    drive(1'b1, 32);
    expect_pop(8'h00, 1, 0, 0, 1, "R7 break entry");
    @(negedge clk);
    check(empty == 1'b1, "R7 single entry", empty, 1);
  endtask

  task automatic t_glitch;
    set_cfg(2'd3, 0, 0, 0);
    drive(1'b0, 3);
    drive(1'b1, 48);
    @(negedge clk);
    check(empty == 1'b1, "R8 glitch rejected", empty, 1);
  endtask

  task automatic t_pop_empty;
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    check(empty == 1'b1, "R11 still empty", empty, 1);
    send(8'h81, 8, 0, 0);
    expect_pop(8'h81, 0, 0, 0, 0, "R11 next char");
    @(negedge clk);
    check(empty == 1'b1, "R11 only entry", empty, 1);
  endtask

  task automatic t_overrun;
    set_cfg(2'd3, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      send(8'(i), 8, 0, 0);
      @(negedge clk);
      if (i == 14) check(full == 1'b0, "R9 not full at 15", full, 0);
    end
    check(full == 1'b1, "R9 full at 16", full, 1);
    send(8'hEE, 8, 0, 0);
    expect_pop(8'h00, 0, 0, 0, 0, "R9 first out");
    send(8'h77, 8, 0, 0);
    @(negedge clk);
    check(full == 1'b1, "R9 full again", full, 1);
    for (int i = 1; i < 16; i++) expect_pop(8'(i), 0, 0, 0, 0, "R9 order");
    expect_pop(8'h77, 0, 1, 0, 0, "R10 overrun tag");
    @(negedge clk);
    check(empty == 1'b1, "R10 dropped char absent", empty, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    rxd   = 1'b1;
    pop   = 1'b0;
    set_cfg(2'd3, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    drive(1'b1, 32);
    t_basic();
    t_length();
    t_parity();
    t_two_stop();
    t_framing();
    t_break();
    t_glitch();
    t_pop_empty();
    t_overrun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule